// File: doc/BRIEF.md
# Repeating Transmit Message Buffer

This block holds a short fixed bit pattern that a processor loads one byte at a time. It inserts that pattern, one bit per insertion slot, into chosen channel bit positions of a framed serial transmit stream. The pattern repeats for as long as the link is enabled. Each pass through the message starts on a transmit multiframe boundary, so the processor can place overhead or data elements at fixed positions relative to the transmit timebase.

Storage is double-banked. Bytes go into a shadow bank, and a commit strobe marks the shadow contents as the next message. The banks swap only when the pass in progress ends, or at once if no pass is running, so back-to-back messages join without a gap. Each entry gives eight bits to the line, or only its six low bits in narrow packing, most significant first. A single-shot setting sends a message once and does not repeat it. This serves links whose framing is added elsewhere.

Instances chain through a pass-through bit and valid pair. The downstream instance wins any slot that both claim. A disabled instance lets upstream data through unchanged.

Top module: `txr_link`

## Requirements
- R1: `cpu_len_m1` carries the message length minus one, so lengths run from 1 to 64 entries. A pass inserts exactly (cpu_len_m1+1) × entry-width bits and then inserts nothing until a new pass starts.
- R2: A pass starts only in a slot where `bit_strobe` and `mf_start` are both high and that slot is a boundary (see R3). Entry 0's first bit is inserted in that same slot.
- R3: With `mf_mode` = 2'b01 (12-frame T1 multiframe), only every second multiframe pulse is a boundary, and the first pulse after entering that mode counts. With codes 2'b00 (24-frame T1), 2'b10 and 2'b11 (16-frame E1), every pulse is a boundary.
- R4: With `pack6_sel` = 0, each entry gives bits 7 down to 0. With `pack6_sel` = 1, each entry gives bits 5 down to 0 and bits 7:6 are never sent.
- R5: Once a pass ends, the same message is sent again from entry 0 at each later boundary.
- R6: A commit that arrives while a pass runs, including in the slot of the pass's final bit, leaves the rest of that pass unchanged. The committed message is sent from the next boundary onward. A commit while no pass runs takes effect at once.
- R7: Between a commit and its bank swap, byte writes and further commits are ignored.
- R8: With `once_sel` = 1, a message is sent for one pass only. After that, boundaries insert nothing until a new commit.
- R9: With `link_en` = 0, `ins_vld` equals `thru_vld` and `ins_bit` equals `thru_bit`.
- R10: While this instance inserts, its bit appears on `ins_bit` whatever `thru_vld` and `thru_bit` are.
- R11: A boundary that arrives during a pass does not restart the pass. The pass continues to its end.
- R12: After reset no message is loaded, and no slot is inserted until a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Byte write strobe into the shadow bank (next sequential entry) |
| cpu_wdata | input | 8 | Byte to store |
| cpu_len_m1 | input | 6 | Message length minus one, sampled on commit |
| cpu_commit | input | 1 | Marks the shadow bank as the next message |
| link_en | input | 1 | Enables insertion |
| pack6_sel | input | 1 | 1: six bits per entry, 0: eight bits per entry |
| once_sel | input | 1 | 1: send each message once, no repeat |
| mf_mode | input | 2 | Multiframe type: 00 24-frame T1, 01 12-frame T1, 10/11 E1 |
| mf_start | input | 1 | Marks the slot as the first bit of a multiframe |
| bit_strobe | input | 1 | One insertion slot of the selected channel |
| thru_vld | input | 1 | Upstream insertion valid |
| thru_bit | input | 1 | Upstream bit or original slot data |
| ins_vld | output | 1 | A bit is inserted in this slot |
| ins_bit | output | 1 | Bit for this slot |

## Verification
A commit can land in the same slot as the last bit of a pass. In that cycle the pass-end swap and the commit acceptance meet. The bench provokes this by raising the commit together with the final insertion strobe. It judges the outcome by checking that the old message's final bit still comes out and that the new message fills the next boundary's pass. A boundary pulse can also arrive while a pass is running. The bench places one on the first bit of a later entry and expects that pass to continue in order, with no restart at entry 0.

// File: rtl/txr_pkg.sv
// Shared types for the repeating transmit message buffer.
package txr_pkg;

    // Multiframe kind of the transmit timebase.
    typedef enum logic [1:0] {
        MF_T1_24 = 2'b00,
        MF_T1_12 = 2'b01,
        MF_E1_16 = 2'b10,
        MF_E1_ALT = 2'b11
    } mf_mode_e;

endpackage

// File: rtl/txr_align.sv
// Boundary qualifier.
// Turns multiframe-start pulses into message boundaries. In the 12-frame T1
// mode, every second pulse is a boundary, so that the message aligns to
// 24 frames. Assumes mf_start means something only together with bit_strobe.
module txr_align
    import txr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mf_mode,
    input  logic       mf_start,
    input  logic       bit_strobe,
    output logic       boundary
);

    logic mf_hit;
    logic short_mf;
    logic phase_q;

    // A multiframe pulse counts only in an insertion slot.
    always_comb begin
        mf_hit   = mf_start & bit_strobe;
        short_mf = (mf_mode == MF_T1_12);
        boundary = mf_hit & (~short_mf | ~phase_q);
    end

    // Tracks which half of the 24-frame span the 12-frame mode is in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (!short_mf) begin
            phase_q <= 1'b0;
        end else if (mf_hit) begin
            phase_q <= ~phase_q;
        end
    end

    // R3: in the 12-frame mode, two boundaries in a row need a skipped pulse between them.
    p_short_mf_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && short_mf) |=> (phase_q || !short_mf));

endmodule

// File: rtl/txr_store.sv
// Double-banked message store.
// The processor fills the shadow bank at a sequential write pointer. A commit
// arms a bank swap, which happens when the engine reports a safe point (pass
// end or idle). Between a commit and its swap, writes and commits are
// dropped. In single-shot mode, the live message is retired at its pass end.
module txr_store #(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned ENTRY_W = 8,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [ENTRY_W-1:0] cpu_wdata,
    input  logic [AW-1:0]      cpu_len_m1,
    input  logic               cpu_commit,
    input  logic               once_sel,
    input  logic               swap_ok,
    input  logic               pass_done,
    input  logic [AW-1:0]      rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [AW-1:0]      act_len_m1,
    output logic               act_valid
);

    logic                          act_sel_q;
    logic                          pending_q;
    logic [AW-1:0]                 pend_len_q;
    logic [AW-1:0]                 wr_ptr_q;
    logic                          wr_fire;
    logic                          commit_take;
    logic                          swap_now;
    logic [AW-1:0]                 next_len;
    logic [1:0][ENTRY_W-1:0]       bank_rd;

    // Decode processor requests against the pending swap.
    always_comb begin
        wr_fire     = cpu_wr & ~pending_q;
        commit_take = cpu_commit & ~pending_q;
        swap_now    = (pending_q | commit_take) & swap_ok;
        next_len    = pending_q ? pend_len_q : cpu_len_m1;
    end

    // One storage bank per side. The live side is read, the other is written.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [ENTRY_W-1:0] mem [DEPTH];

        // Writes land only in the bank that is currently the shadow.
        always_ff @(posedge clk) begin
            if (wr_fire && (act_sel_q != b[0])) begin
                mem[wr_ptr_q] <= cpu_wdata;
            end
        end

        assign bank_rd[b] = mem[rd_idx];
    end

    assign rd_data = bank_rd[act_sel_q];

    // Sequential shadow write pointer. It restarts at each accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (commit_take) begin
            wr_ptr_q <= '0;
        end else if (wr_fire) begin
            wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    // Pending-swap flag and the length held for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q  <= 1'b0;
            pend_len_q <= '0;
        end else begin
            if (swap_now) begin
                pending_q <= 1'b0;
            end else if (commit_take) begin
                pending_q <= 1'b1;
            end
            if (commit_take) begin
                pend_len_q <= cpu_len_m1;
            end
        end
    end

    // Live bank select, live length and message-present flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel_q  <= 1'b0;
            act_len_m1 <= '0;
            act_valid  <= 1'b0;
        end else if (swap_now) begin
            act_sel_q  <= ~act_sel_q;
            act_len_m1 <= next_len;
            act_valid  <= 1'b1;
        end else if (pass_done && once_sel) begin
            act_valid  <= 1'b0;
        end
    end

    // R6: the live bank changes only at a point the engine marked safe.
    p_swap_at_safe_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel_q != $past(act_sel_q)) |-> $past(swap_ok));

    // R7: a write during a pending swap does not move the write pointer.
    p_pending_blocks_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && cpu_wr) |=> $stable(wr_ptr_q));

    // R8: in single-shot mode the message is retired after its pass.
    p_once_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_done && once_sel && !pending_q && !cpu_commit) |=> !act_valid);

endmodule

// File: rtl/txr_engine.sv
// Pass engine.
// Walks the live message entry by entry and bit by bit, one bit per strobe,
// most significant first. A pass starts only on a boundary, and boundaries
// during a pass are ignored. Assumes the store's live length and bank stay
// fixed while a pass runs (the store swaps only at swap_ok).
module txr_engine #(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned ENTRY_W  = 8,
    parameter int unsigned NARROW_W = 6,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned BW      = $clog2(ENTRY_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_en,
    input  logic               pack6_sel,
    input  logic               bit_strobe,
    input  logic               boundary,
    input  logic               act_valid,
    input  logic [AW-1:0]      act_len_m1,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic [AW-1:0]      rd_idx,
    output logic               own_vld,
    output logic               own_bit,
    output logic               swap_ok,
    output logic               pass_done
);

    logic          running_q;
    logic [AW-1:0] ent_q;
    logic [BW-1:0] bit_q;
    logic          start_now;
    logic          live;
    logic [BW-1:0] top_bit;
    logic [AW-1:0] cur_ent;
    logic [BW-1:0] cur_bit;
    logic          last_bit;
    logic          last_ent;

    // Slot decode: which entry and bit this strobe carries, and whether the pass ends.
    always_comb begin
        top_bit   = pack6_sel ? BW'(NARROW_W - 1) : BW'(ENTRY_W - 1);
        start_now = link_en & ~running_q & act_valid & boundary;
        live      = link_en & bit_strobe & (running_q | start_now);
        cur_ent   = running_q ? ent_q : '0;
        cur_bit   = running_q ? bit_q : top_bit;
        last_bit  = (cur_bit == '0);
        last_ent  = (cur_ent == act_len_m1);
        pass_done = live & last_bit & last_ent;
        swap_ok   = pass_done | (~running_q & ~start_now);
        rd_idx    = cur_ent;
        own_vld   = live;
        own_bit   = rd_data[cur_bit];
    end

    // Pass state and bit pointers. Disabling drops any pass in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            running_q <= 1'b0;
            ent_q     <= '0;
            bit_q     <= '0;
        end else if (live) begin
            if (pass_done) begin
                running_q <= 1'b0;
                ent_q     <= '0;
                bit_q     <= '0;
            end else begin
                running_q <= 1'b1;
                if (last_bit) begin
                    ent_q <= cur_ent + 1'b1;
                    bit_q <= top_bit;
                end else begin
                    ent_q <= cur_ent;
                    bit_q <= cur_bit - 1'b1;
                end
            end
        end
    end

    // R2: a pass is entered only from a boundary slot.
    p_start_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_q) |-> $past(boundary));

    // R1: the entry pointer stays inside the live message length.
    p_ptr_in_length_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (ent_q <= act_len_m1));

    // R11: a boundary during a pass does not end or restart it.
    p_mid_pass_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && boundary && link_en && !pass_done) |=> running_q);

endmodule

// File: rtl/txr_link.sv
// Repeating transmit message buffer, top level.
// Joins the boundary qualifier, the double-banked store and the pass engine.
// Merges this instance's bit over the upstream pass-through pair, so the
// downstream instance in a chain wins any shared slot.
module txr_link
    import txr_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned ENTRY_W  = 8,
    parameter int unsigned NARROW_W = 6,
    localparam int unsigned AW      = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [ENTRY_W-1:0] cpu_wdata,
    input  logic [AW-1:0]      cpu_len_m1,
    input  logic               cpu_commit,
    input  logic               link_en,
    input  logic               pack6_sel,
    input  logic               once_sel,
    input  logic [1:0]         mf_mode,
    input  logic               mf_start,
    input  logic               bit_strobe,
    input  logic               thru_vld,
    input  logic               thru_bit,
    output logic               ins_vld,
    output logic               ins_bit
);

    logic               boundary;
    logic [AW-1:0]      rd_idx;
    logic [ENTRY_W-1:0] rd_data;
    logic [AW-1:0]      act_len_m1;
    logic               act_valid;
    logic               own_vld;
    logic               own_bit;
    logic               swap_ok;
    logic               pass_done;

    txr_align i_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .mf_mode    (mf_mode),
        .mf_start   (mf_start),
        .bit_strobe (bit_strobe),
        .boundary   (boundary)
    );

    txr_store #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_len_m1 (cpu_len_m1),
        .cpu_commit (cpu_commit),
        .once_sel   (once_sel),
        .swap_ok    (swap_ok),
        .pass_done  (pass_done),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .act_len_m1 (act_len_m1),
        .act_valid  (act_valid)
    );

    txr_engine #(
        .DEPTH    (DEPTH),
        .ENTRY_W  (ENTRY_W),
        .NARROW_W (NARROW_W)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_en    (link_en),
        .pack6_sel  (pack6_sel),
        .bit_strobe (bit_strobe),
        .boundary   (boundary),
        .act_valid  (act_valid),
        .act_len_m1 (act_len_m1),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .own_vld    (own_vld),
        .own_bit    (own_bit),
        .swap_ok    (swap_ok),
        .pass_done  (pass_done)
    );

    // Priority merge: this instance's bit overrides the upstream slot data.
    always_comb begin
        ins_vld = own_vld | thru_vld;
        ins_bit = own_vld ? own_bit : thru_bit;
    end

    // R9: a disabled link is transparent to the upstream pair.
    p_disabled_transparent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |-> ((ins_vld == thru_vld) && (!thru_vld || (ins_bit == thru_bit))));

    // R12: nothing is inserted before any message was swapped in.
    p_no_insert_without_msg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_valid && !thru_vld) |-> !ins_vld);

endmodule

// File: tb/test_txr_link.sv
// Scoreboard bench: slot tasks queue the expected output of each insertion
// slot, and a monitor pops and compares at the falling edge.
module test_txr_link;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [5:0] cpu_len_m1 = '0;
    logic       cpu_commit = 1'b0;
    logic       link_en = 1'b1;
    logic       pack6_sel = 1'b0;
    logic       once_sel = 1'b0;
    logic [1:0] mf_mode = 2'b00;
    logic       mf_start = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       thru_vld = 1'b0;
    logic       thru_bit = 1'b0;
    logic       ins_vld;
    logic       ins_bit;

    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;
    bit         tb_thru_v = 1'b0;
    bit         tb_thru_b = 1'b0;
    bit         commit_flag = 1'b0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] e_item;
    string      e_tag;

    always #5 clk = ~clk;

    txr_link i_txr_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_len_m1 (cpu_len_m1),
        .cpu_commit (cpu_commit),
        .link_en    (link_en),
        .pack6_sel  (pack6_sel),
        .once_sel   (once_sel),
        .mf_mode    (mf_mode),
        .mf_start   (mf_start),
        .bit_strobe (bit_strobe),
        .thru_vld   (thru_vld),
        .thru_bit   (thru_bit),
        .ins_vld    (ins_vld),
        .ins_bit    (ins_bit)
    );

    // Monitor: compare each strobed slot with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && bit_strobe) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected slot: actual vld=%0b bit=%0b expected none", ins_vld, ins_bit);
            end else begin
                e_item = exp_q.pop_front();
                e_tag  = tag_q.pop_front();
                if ({ins_vld, ins_bit} !== e_item) begin
                    failures++;
                    $display("FAIL %s: actual vld=%0b bit=%0b expected vld=%0b bit=%0b",
                             e_tag, ins_vld, ins_bit, e_item[1], e_item[0]);
                end
            end
        end
    end

    // One insertion slot: drive for one cycle, queue the expected output.
    task automatic slot(input bit mf, input bit ev, input bit eb, input string tag);
        @(posedge clk); #1;
        bit_strobe = 1'b1;
        mf_start   = mf;
        thru_vld   = tb_thru_v;
        thru_bit   = tb_thru_b;
        cpu_commit = commit_flag;
        exp_q.push_back({ev, eb});
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bit_strobe  = 1'b0;
        mf_start    = 1'b0;
        cpu_commit  = 1'b0;
        commit_flag = 1'b0;
    endtask

    // Expected insertion of one entry, MSB first. mfpos marks the bit carrying mf_start.
    task automatic exp_byte(input logic [7:0] b, input bit p6, input int mfpos, input string tag);
        int w;
        w = p6 ? 6 : 8;
        for (int i = w - 1; i >= 0; i--) begin
            slot(i == mfpos, 1'b1, b[i], tag);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #1;
        cpu_wr = 1'b1;
        cpu_wdata = d;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    task automatic commit(input logic [5:0] len_m1);
        @(posedge clk); #1;
        cpu_len_m1 = len_m1;
        cpu_commit = 1'b1;
        @(posedge clk); #1;
        cpu_commit = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (ins_vld !== 1'b0) begin
            failures++;
            $display("FAIL R12 reset: actual vld=%0b expected vld=0", ins_vld);
        end

        // R12: a boundary with no message loaded inserts nothing.
        slot(1'b1, 1'b0, 1'b0, "R12 no message");

        // Two-entry message, pack8, 24-frame mode.
        wr(8'hA5);
        wr(8'h3C);
        commit(6'd1);
        exp_byte(8'hA5, 1'b0, 7, "R2 start aligned / R4 pack8");
        exp_byte(8'h3C, 1'b0, -1, "R1 second entry");
        slot(1'b0, 1'b0, 1'b0, "R1 pass length");
        slot(1'b0, 1'b0, 1'b0, "R1 pass length");
        exp_byte(8'hA5, 1'b0, 7, "R5 repeat");
        exp_byte(8'h3C, 1'b0, 7, "R11 mid-pass boundary");

        // R6 / R7: commit mid-pass, then ignored writes and commit.
        exp_byte(8'hA5, 1'b0, 7, "R6 pass before commit");
        wr(8'h0F);
        commit(6'd0);
        wr(8'hFF);
        commit(6'd3);
        cpu_len_m1 = 6'd0;
        exp_byte(8'h3C, 1'b0, -1, "R6 current pass kept");
        slot(1'b0, 1'b0, 1'b0, "R6 gap after pass");
        exp_byte(8'h0F, 1'b0, 7, "R6 new message");
        slot(1'b0, 1'b0, 1'b0, "R7 length kept");
        exp_byte(8'h0F, 1'b0, 7, "R7 data kept");

        // R4: narrow packing uses bits 5..0.
        wr(8'h2D);
        wr(8'hC6);
        commit(6'd1);
        pack6_sel = 1'b1;
        exp_byte(8'h2D, 1'b1, 5, "R4 pack6");
        exp_byte(8'hC6, 1'b1, -1, "R4 pack6 low bits");
        slot(1'b0, 1'b0, 1'b0, "R4 pack6 pass end");

        // R3: 12-frame mode skips every second pulse.
        mf_mode = 2'b01;
        exp_byte(8'h2D, 1'b1, 5, "R3 first boundary");
        exp_byte(8'hC6, 1'b1, -1, "R3 first pass");
        slot(1'b1, 1'b0, 1'b0, "R3 skipped pulse");
        exp_byte(8'h2D, 1'b1, 5, "R3 next boundary");
        exp_byte(8'hC6, 1'b1, -1, "R3 next pass");
        mf_mode = 2'b00;
        pack6_sel = 1'b0;

        // R9: disabled link passes upstream data.
        link_en = 1'b0;
        tb_thru_v = 1'b1;
        tb_thru_b = 1'b1;
        slot(1'b1, 1'b1, 1'b1, "R9 disabled thru one");
        tb_thru_b = 1'b0;
        slot(1'b0, 1'b1, 1'b0, "R9 disabled thru zero");
        tb_thru_v = 1'b0;
        slot(1'b1, 1'b0, 1'b0, "R9 disabled no insert");
        link_en = 1'b1;

        // R10: own bits override the upstream pair.
        tb_thru_v = 1'b1;
        tb_thru_b = 1'b1;
        exp_byte(8'h2D, 1'b0, 7, "R10 override");
        tb_thru_b = 1'b0;
        exp_byte(8'hC6, 1'b0, -1, "R10 override");
        tb_thru_b = 1'b1;
        slot(1'b0, 1'b1, 1'b1, "R10 thru after pass");
        tb_thru_v = 1'b0;
        tb_thru_b = 1'b0;

        // R8: single-shot mode sends one pass only.
        once_sel = 1'b1;
        wr(8'h81);
        commit(6'd0);
        exp_byte(8'h81, 1'b0, 7, "R8 single pass");
        slot(1'b1, 1'b0, 1'b0, "R8 no repeat");
        slot(1'b1, 1'b0, 1'b0, "R8 no repeat");
        once_sel = 1'b0;

        // R6: commit in the same slot as the final bit, E1 mode.
        mf_mode = 2'b10;
        wr(8'h5A);
        commit(6'd0);
        wr(8'hC3);
        cpu_len_m1 = 6'd0;
        for (int i = 7; i >= 1; i--) begin
            slot(i == 7, 1'b1, 8'h5A >> i & 1'b1, "R2 E1 pass");
        end
        commit_flag = 1'b1;
        slot(1'b0, 1'b1, 1'b0, "R6 commit on last bit");
        slot(1'b0, 1'b0, 1'b0, "R6 gap after last bit");
        exp_byte(8'hC3, 1'b0, 7, "R6 joined message");
        exp_byte(8'hC3, 1'b0, 7, "R5 joined message repeats");

        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1 scoreboard drain: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule